// File: doc/BRIEF.md
# Subarray Refresh-Access Conflict Gate

This block sits in front of one DRAM bank and decides, cycle by cycle, whether a row activation may go out while that bank is refreshing. A refresh is not treated as a bank-wide lock. Only the subarray under refresh is fenced off. An activation aimed at any other subarray of the same bank goes ahead at once. An activation aimed at the refreshing subarray is parked in a single holding slot, with its row latched, until the refresh lock lapses.

The refresh row and the access row leave the block on two separate output buses, so both can be presented in the same cycle. An activation-window checker keeps the ages of the last four activations. It applies the normal spacing limits when no refresh is running. While a refresh is in progress it applies a pair of longer limits, which cover the extra current drawn when a refresh and activations overlap. All timing limits arrive as run-time inputs.

Top module: `sa_refresh_gate`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `acc_grant`, `acc_stall`, `ref_busy` and `ref_done` are all low.
- R2: A `ref_start` pulse sampled while idle raises `ref_busy` from the next cycle for exactly `t_rfc` cycles. During that time `ref_row_o` equals `{ref_sa, ref_local_row}` as sampled with the pulse.
- R3: `ref_done` is high for exactly one cycle, the first cycle in which `ref_busy` is low again after a refresh.
- R4: A `ref_start` sampled while `ref_busy` is high is ignored. The running refresh keeps its row and its end cycle.
- R5: The subarray of an access is the top log2(SA_COUNT) bits of its row address. The lower bits play no part in the conflict decision.
- R6: An accepted access whose subarray differs from the refreshing one, or any accepted access when no refresh runs, is granted in the cycle after it is sampled, provided the activation limits allow it. `acc_row_o` carries its row during the grant cycle.
- R7: An accepted access to the refreshing subarray raises `acc_stall` and holds its latched row on `acc_row_o`. It is granted in the first cycle in which `ref_busy` is low.
- R8: A request is accepted only when the holding slot is empty or is being granted in that cycle. A request sampled while an access is stalled is dropped and never granted.
- R9: Two grants are at least `t_rrd` cycles apart. When `ref_busy` is high in the cycle of the later grant, the minimum spacing is `t_rrd_ext` instead.
- R10: A grant comes at least `t_faw` cycles after the fourth most recent grant. When `ref_busy` is high in the cycle of that grant, the minimum gap is `t_faw_ext` instead.
- R11: The refresh row and the granted access row are driven on separate buses in the same cycle while a refresh runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_start | input | 1 | One-cycle refresh start request |
| ref_sa | input | log2(SA_COUNT) | Subarray to refresh |
| ref_local_row | input | ROW_W-log2(SA_COUNT) | Row inside that subarray |
| acc_req | input | 1 | Activation request |
| acc_row | input | ROW_W | Activation row address |
| t_rfc | input | 8 | Refresh lock length in cycles |
| t_rrd | input | 8 | Normal minimum activation spacing |
| t_rrd_ext | input | 8 | Activation spacing while refreshing |
| t_faw | input | 8 | Normal four-activation window |
| t_faw_ext | input | 8 | Four-activation window while refreshing |
| acc_grant | output | 1 | Activation issued this cycle |
| acc_stall | output | 1 | An access is held and not issued this cycle |
| acc_row_o | output | ROW_W | Access row path |
| ref_busy | output | 1 | Refresh lock active |
| ref_done | output | 1 | Refresh completion pulse |
| ref_row_o | output | ROW_W | Refresh row path |

## Verification
A request driven before the edge that samples it is granted in the very next cycle when the path is clear. When a limit or a conflict intervenes, it is granted in the first cycle in which the blocking age reaches its limit or `ref_busy` falls. The refresh lock runs from the cycle after the start pulse through cycle `t_rfc`, and `ref_done` follows one cycle later. The bench counts cycles on the rising edge and samples on the falling edge. For each request it queues the exact expected grant cycle and row, worked out from these rules. The monitor compares `ref_busy`, `ref_done` and `ref_row_o` every cycle against a model of the refresh window that the bench starts itself.

// File: rtl/sa_gate_pkg.sv
package sa_gate_pkg;
  localparam int TIME_W = 8;
  typedef logic [TIME_W-1:0] tick_t;

  typedef enum logic {
    MODE_NORMAL = 1'b0,
    MODE_EXT    = 1'b1
  } win_mode_e;

  function automatic tick_t tick_inc_sat(input tick_t a);
    return (a == '1) ? a : a + tick_t'(1);
  endfunction

  function automatic tick_t pick_limit(input win_mode_e m, input tick_t n, input tick_t e);
    return (m == MODE_EXT) ? e : n;
  endfunction

  function automatic tick_t lock_load(input tick_t len);
    return (len == '0) ? '0 : len - tick_t'(1);
  endfunction
endpackage

// File: rtl/sa_ref_tracker.sv
module sa_ref_tracker
  import sa_gate_pkg::*;
#(
  parameter int SA_W  = 3,
  parameter int LOC_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_start,
  input  logic [SA_W-1:0]  ref_sa_in,
  input  logic [LOC_W-1:0] ref_loc_in,
  input  tick_t            t_rfc,
  output logic             busy,
  output logic             done,
  output logic [SA_W-1:0]  sa_q,
  output logic [LOC_W-1:0] loc_q
);
  tick_t remain;
  logic  start_take;
  logic  lock_end;

  assign start_take = ref_start && !busy;
  assign lock_end   = busy && (remain == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      remain <= '0;
      sa_q   <= '0;
      loc_q  <= '0;
    end else begin
      done <= lock_end;
      if (start_take) begin
        busy   <= 1'b1;
        remain <= lock_load(t_rfc);
        sa_q   <= ref_sa_in;
        loc_q  <= ref_loc_in;
      end else if (lock_end) begin
        busy <= 1'b0;
      end else if (busy) begin
        remain <= remain - tick_t'(1);
      end
    end
  end

  // R4
  ignore_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ref_start) |=> ($stable(sa_q) && $stable(loc_q)));

  // R3
  done_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
endmodule

// File: rtl/sa_act_window.sv
module sa_act_window
  import sa_gate_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  act_fire,
  input  logic  ext_mode,
  input  tick_t t_rrd,
  input  tick_t t_rrd_ext,
  input  tick_t t_faw,
  input  tick_t t_faw_ext,
  output logic  act_ok
);
  localparam int OLDEST = DEPTH - 1;

  tick_t     age [DEPTH];
  win_mode_e mode;
  tick_t     rrd_lim;
  tick_t     faw_lim;
  logic      rrd_met;
  logic      faw_met;

  assign mode    = ext_mode ? MODE_EXT : MODE_NORMAL;
  assign rrd_lim = pick_limit(mode, t_rrd, t_rrd_ext);
  assign faw_lim = pick_limit(mode, t_faw, t_faw_ext);
  assign rrd_met = (age[0] >= rrd_lim);
  assign faw_met = (age[OLDEST] >= faw_lim);
  assign act_ok  = rrd_met && faw_met;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n)        age[i] <= '1;
        else if (act_fire) age[i] <= tick_t'(1);
        else               age[i] <= tick_inc_sat(age[i]);
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (!rst_n)        age[i] <= '1;
        else if (act_fire) age[i] <= tick_inc_sat(age[i-1]);
        else               age[i] <= tick_inc_sat(age[i]);
      end
    end
  end

  // R9
  rrd_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_fire |-> (age[0] >= rrd_lim));

  // R10
  faw_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_fire |-> (age[OLDEST] >= faw_lim));
endmodule

// File: rtl/sa_acc_slot.sv
module sa_acc_slot #(
  parameter int ROW_W = 12,
  parameter int SA_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_req,
  input  logic [ROW_W-1:0] acc_row,
  input  logic             blocked,
  output logic             pending,
  output logic             grant,
  output logic             stall,
  output logic [ROW_W-1:0] row_q,
  output logic [SA_W-1:0]  sa_q
);
  function automatic logic [SA_W-1:0] sa_of(input logic [ROW_W-1:0] row);
    return row[ROW_W-1 -: SA_W];
  endfunction

  logic take;

  assign grant = pending && !blocked;
  assign stall = pending && blocked;
  assign take  = acc_req && (!pending || grant);
  assign sa_q  = sa_of(row_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      row_q   <= '0;
    end else if (take) begin
      pending <= 1'b1;
      row_q   <= acc_row;
    end else if (grant) begin
      pending <= 1'b0;
    end
  end

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (pending && $stable(row_q)));

  // R8
  drop_when_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && acc_req) |=> $stable(row_q));
endmodule

// File: rtl/sa_refresh_gate.sv
module sa_refresh_gate
  import sa_gate_pkg::*;
#(
  parameter int ROW_W    = 12,
  parameter int SA_COUNT = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ref_start,
  input  logic [$clog2(SA_COUNT)-1:0]  ref_sa,
  input  logic [ROW_W-$clog2(SA_COUNT)-1:0] ref_local_row,
  input  logic                         acc_req,
  input  logic [ROW_W-1:0]             acc_row,
  input  logic [7:0]                   t_rfc,
  input  logic [7:0]                   t_rrd,
  input  logic [7:0]                   t_rrd_ext,
  input  logic [7:0]                   t_faw,
  input  logic [7:0]                   t_faw_ext,
  output logic                         acc_grant,
  output logic                         acc_stall,
  output logic [ROW_W-1:0]             acc_row_o,
  output logic                         ref_busy,
  output logic                         ref_done,
  output logic [ROW_W-1:0]             ref_row_o
);
  localparam int SA_W  = $clog2(SA_COUNT);
  localparam int LOC_W = ROW_W - SA_W;

  logic [SA_W-1:0]  lock_sa;
  logic [LOC_W-1:0] lock_loc;
  logic [SA_W-1:0]  slot_sa;
  logic             slot_pending;
  logic             sa_conflict;
  logic             act_ok;
  logic             slot_blocked;

  sa_ref_tracker #(.SA_W(SA_W), .LOC_W(LOC_W)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_start  (ref_start),
    .ref_sa_in  (ref_sa),
    .ref_loc_in (ref_local_row),
    .t_rfc      (tick_t'(t_rfc)),
    .busy       (ref_busy),
    .done       (ref_done),
    .sa_q       (lock_sa),
    .loc_q      (lock_loc)
  );

  assign ref_row_o    = {lock_sa, lock_loc};
  assign sa_conflict  = ref_busy && (slot_sa == lock_sa);
  assign slot_blocked = sa_conflict || !act_ok;

  sa_acc_slot #(.ROW_W(ROW_W), .SA_W(SA_W)) u_slot (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc_req (acc_req),
    .acc_row (acc_row),
    .blocked (slot_blocked),
    .pending (slot_pending),
    .grant   (acc_grant),
    .stall   (acc_stall),
    .row_q   (acc_row_o),
    .sa_q    (slot_sa)
  );

  sa_act_window #(.DEPTH(4)) u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .act_fire  (acc_grant),
    .ext_mode  (ref_busy),
    .t_rrd     (tick_t'(t_rrd)),
    .t_rrd_ext (tick_t'(t_rrd_ext)),
    .t_faw     (tick_t'(t_faw)),
    .t_faw_ext (tick_t'(t_faw_ext)),
    .act_ok    (act_ok)
  );

  // R6
  no_locked_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_grant && ref_busy) |-> (acc_row_o[ROW_W-1 -: SA_W] != ref_row_o[ROW_W-1 -: SA_W]));

  // R7
  release_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_pending && $fell(ref_busy) && act_ok) |-> acc_grant);
endmodule

// File: tb/sa_refresh_gate_test.sv
`timescale 1ns/1ps
module sa_refresh_gate_test;
  localparam int RFC = 40, RRD = 2, RRDX = 4, FAW = 10, FAWX = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_start = 1'b0;
  logic [2:0] ref_sa = '0;
  logic [8:0] ref_local_row = '0;
  logic acc_req = 1'b0;
  logic [11:0] acc_row = '0;
  logic [7:0] t_rfc = 8'(RFC), t_rrd = 8'(RRD), t_rrd_ext = 8'(RRDX);
  logic [7:0] t_faw = 8'(FAW), t_faw_ext = 8'(FAWX);
  logic acc_grant, acc_stall, ref_busy, ref_done;
  logic [11:0] acc_row_o, ref_row_o;

  sa_refresh_gate uut (
    .clk(clk), .rst_n(rst_n), .ref_start(ref_start), .ref_sa(ref_sa),
    .ref_local_row(ref_local_row), .acc_req(acc_req), .acc_row(acc_row),
    .t_rfc(t_rfc), .t_rrd(t_rrd), .t_rrd_ext(t_rrd_ext), .t_faw(t_faw),
    .t_faw_ext(t_faw_ext), .acc_grant(acc_grant), .acc_stall(acc_stall),
    .acc_row_o(acc_row_o), .ref_busy(ref_busy), .ref_done(ref_done),
    .ref_row_o(ref_row_o)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0, grants_seen = 0;
  bit finished = 1'b0, mon_on = 1'b0;
  int exp_cyc_q[$];
  logic [11:0] exp_row_q[$];
  string exp_tag_q[$];
  bit ref_model_on = 1'b0;
  int rs = 0;
  logic [11:0] exp_ref_row = '0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  // monitor: scoreboard pops and refresh window model
  always @(negedge clk) begin
    if (mon_on) begin
      bit eb, ed;
      eb = ref_model_on && (cyc >= rs + 1) && (cyc <= rs + RFC);
      ed = ref_model_on && (cyc == rs + RFC + 1);
      chk(ref_busy == eb, "R2 busy", ref_busy, eb);
      chk(ref_done == ed, "R3 done", ref_done, ed);
      if (eb) chk(ref_row_o == exp_ref_row, "R4 refresh row", ref_row_o, exp_ref_row);
      if (acc_grant) begin
        grants_seen++;
        if (exp_cyc_q.size() == 0) begin
          chk(1'b0, "R8 unexpected grant", acc_row_o, 0);
        end else begin
          int ec;
          logic [11:0] er;
          string et;
          ec = exp_cyc_q.pop_front();
          er = exp_row_q.pop_front();
          et = exp_tag_q.pop_front();
          chk(cyc == ec, et, cyc, ec);
          chk(acc_row_o == er, et, acc_row_o, er);
        end
        if (eb) chk(ref_row_o == exp_ref_row && acc_row_o != ref_row_o, "R11 dual path",
                    ref_row_o, exp_ref_row);
      end
    end
  end

  task automatic push_exp(input int c, input logic [11:0] r, input string t);
    exp_cyc_q.push_back(c);
    exp_row_q.push_back(r);
    exp_tag_q.push_back(t);
  endtask

  task automatic pulse_ref(input logic [2:0] sa, input logic [8:0] loc, input bit model);
    ref_start = 1'b1; ref_sa = sa; ref_local_row = loc;
    if (model) begin
      rs = cyc; ref_model_on = 1'b1; exp_ref_row = {sa, loc};
    end
    @(negedge clk);
    ref_start = 1'b0;
  endtask

  task automatic send(input logic [11:0] row, input int ec, input string t);
    push_exp(ec, row, t);
    acc_req = 1'b1; acc_row = row;
    @(negedge clk);
    acc_req = 1'b0; acc_row = 12'hFFF;
    while (acc_stall) @(negedge clk);
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int s, k;
    repeat (3) @(negedge clk);
    chk(!acc_grant && !acc_stall && !ref_busy && !ref_done, "R1 in reset",
        {acc_grant, acc_stall, ref_busy, ref_done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!acc_grant && !acc_stall && !ref_busy && !ref_done, "R1 after reset",
        {acc_grant, acc_stall, ref_busy, ref_done}, 0);
    mon_on = 1'b1;

    // plain access, no refresh
    k = cyc;
    send({3'd2, 9'h011}, k + 1, "R5 idle grant");
    repeat (20) @(negedge clk);

    // refresh of subarray 3 with a parallel and a conflicting access
    s = cyc;
    pulse_ref(3'd3, 9'h055, 1'b1);
    send({3'd5, 9'h055}, s + 2, "R6 other subarray");
    pulse_ref(3'd6, 9'h1FF, 1'b0);               // R4: ignored restart
    push_exp(s + RFC + 1, {3'd3, 9'h0AA}, "R7 release grant");
    acc_req = 1'b1; acc_row = {3'd3, 9'h0AA};
    @(negedge clk);
    acc_req = 1'b0; acc_row = 12'h000;
    wait_until(s + 6);
    acc_req = 1'b1; acc_row = {3'd5, 9'h077};    // R8: dropped while stalled
    @(negedge clk);
    acc_req = 1'b0; acc_row = 12'hFFF;
    wait_until(s + 20);
    chk(acc_stall == 1'b1, "R7 stall", acc_stall, 1);
    chk(acc_row_o == {3'd3, 9'h0AA}, "R7 held row", acc_row_o, {3'd3, 9'h0AA});
    wait_until(s + RFC + 4);
    chk(grants_seen == 3, "R8 grant count", grants_seen, 3);
    repeat (20) @(negedge clk);

    // normal limits burst
    k = cyc;
    send({3'd1, 9'h001}, k + 1,  "R9 burst1");
    send({3'd2, 9'h002}, k + 3,  "R9 burst2");
    send({3'd4, 9'h003}, k + 5,  "R9 burst3");
    send({3'd6, 9'h004}, k + 7,  "R9 burst4");
    send({3'd7, 9'h005}, k + 11, "R10 burst5");
    repeat (20) @(negedge clk);

    // extended limits burst under refresh of subarray 0
    pulse_ref(3'd0, 9'h100, 1'b1);
    k = cyc;
    send({3'd1, 9'h010}, k + 1,  "R9 ext1");
    send({3'd1, 9'h011}, k + 5,  "R9 ext2");
    send({3'd1, 9'h012}, k + 9,  "R9 ext3");
    send({3'd1, 9'h013}, k + 13, "R9 ext4");
    send({3'd1, 9'h014}, k + 17, "R10 ext5");
    repeat (50) @(negedge clk);

    chk(exp_cyc_q.size() == 0, "R6 all granted", exp_cyc_q.size(), 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule